// File: doc/BRIEF.md
# Auto-Incrementing Video Memory Access Port

This block is the host-facing register window of a video controller. A host processor on an asynchronous 8-bit bus, with active-low chip-select, read-strobe and write-strobe, sees four byte registers. Three of them hold a 17-bit video memory pointer and a step selector. The fourth is a data port. Reading the data port returns the video memory byte at the pointer, and writing it stores a byte there. Either kind of data-port access then advances the pointer by the programmed step. This lets the host stream through video memory with no need to reload the address.

The bus strobes are asynchronous to the core clock, so they pass through a synchronizer. Access start and end are detected on the synchronized signals. The register offset of a read is captured when the access is first recognised, not when it ends. As a result, the post-read advance fires correctly even if the host changes the address lines before it releases chip-select or read-strobe. The byte for the data port is prefetched from a synchronous memory, which sits outside the block, whenever the pointer changes. A read therefore returns at once.

Top module: `vmem_host_port`

## Requirements
- R1: After reset the pointer and the step selector are zero, and `bus_rdata` reads 0x00.
- R2: Writes to offset 0 and offset 1 load pointer bits 7:0 and 15:8. A write to offset 2 loads pointer bit 16 from data bit 0 and the selector from data bits 7:4, and data bits 3:1 are dropped. Reading these offsets returns the same fields, with bits 3:1 of offset 2 reading zero.
- R3: A read of offset 3 returns the video memory byte at the current pointer. `bus_rdata` is loaded once, when the read is recognised, and then holds its value.
- R4: After a data-port read ends, the pointer advances by the step. Selector 0 gives a step of 0, and selector n (1 to 15) gives a step of 2^(n-1). For example, writing 0x00, 0xB9 and 0x11 to offsets 0, 1 and 2 makes two consecutive data reads return the bytes at 0x1B900 and 0x1B901.
- R5: The register offset of a read is taken when the read is recognised. A data-port read still advances the pointer if the address changes before the strobes are released. A read of another offset does not advance the pointer, even if the address becomes 3 before release.
- R6: Nothing happens unless chip-select and a strobe are both low. A strobe with chip-select high leaves the pointer and the memory unchanged.
- R7: A write to offset 3 stores the data byte at the pointer, then advances the pointer by the same rule as a read.
- R8: The pointer wraps modulo 2^17.
- R9: After any pointer register write, the next data-port read returns the byte at the new pointer.
- R10: A single access gives exactly one advance, however long its strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_cs_n | input | 1 | Host chip-select, active low, asynchronous |
| bus_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, held from read start |
| mem_addr | output | 17 | Video memory address (the pointer) |
| mem_rd_en | output | 1 | Video memory read request |
| mem_wr_en | output | 1 | Video memory write request |
| mem_wdata | output | 8 | Video memory write data |
| mem_rdata | input | 8 | Video memory read data, one cycle after request |

## Verification
The hardest case to reach is a data-port read whose address lines leave offset 3 while the strobes are still asserted. The bus is then released on a different offset, and a design that decodes at release would skip the advance. The bench drives the reverse case too: it moves a pointer-register read onto offset 3 just before release, and then reads the pointer back to check that it did not move. Stray strobes with chip-select high are also driven, and so are strobes held for tens of cycles. Each is followed by a read of the pointer through the register window.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  localparam int PTR_W = 17;
  localparam int DW    = 8;
  localparam int OFF_W = 2;
  localparam int SEL_W = 4;

  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [DW-1:0]    byte_t;
  typedef logic [OFF_W-1:0] off_t;
  typedef logic [SEL_W-1:0] sel_t;

  localparam off_t OFF_LO   = 2'd0;
  localparam off_t OFF_MID  = 2'd1;
  localparam off_t OFF_HI   = 2'd2;
  localparam off_t OFF_PORT = 2'd3;

  // selector 0 -> no step, n -> 2^(n-1)
  function automatic ptr_t step_of(sel_t s);
    if (s == '0) return '0;
    return ptr_t'(1) << (s - sel_t'(1));
  endfunction

  function automatic ptr_t ptr_next(ptr_t p, sel_t s);
    return p + step_of(s);
  endfunction

  function automatic ptr_t ptr_load(ptr_t p, off_t o, byte_t d);
    ptr_t r;
    r = p;
    case (o)
      OFF_LO:  r[7:0]  = d;
      OFF_MID: r[15:8] = d;
      OFF_HI:  r[16]   = d[0];
      default: r = p;
    endcase
    return r;
  endfunction

  function automatic byte_t read_mux(off_t o, ptr_t p, sel_t s, byte_t pre);
    case (o)
      OFF_LO:  return p[7:0];
      OFF_MID: return p[15:8];
      OFF_HI:  return {s, 3'b000, p[16]};
      default: return pre;
    endcase
  endfunction
endpackage

// File: rtl/vmem_bus_sync.sv
module vmem_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_start,
  output logic rd_end,
  output logic wr_start,
  output logic wr_end
);
  localparam int LAST = STAGES - 1;

  logic [2:0] stg [STAGES];
  logic       rd_act, wr_act, rd_act_q, wr_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= 3'b111;
    else        stg[0] <= {cs_n, rd_n, wr_n};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= 3'b111;
      else        stg[g] <= stg[g-1];
    end
  end

  assign rd_act = ~stg[LAST][2] & ~stg[LAST][1];
  assign wr_act = ~stg[LAST][2] & ~stg[LAST][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
    end
  end

  assign rd_start = rd_act & ~rd_act_q;
  assign rd_end   = ~rd_act & rd_act_q;
  assign wr_start = wr_act & ~wr_act_q;
  assign wr_end   = ~wr_act & wr_act_q;
endmodule

// File: rtl/vmem_access_ctl.sv
module vmem_access_ctl
  import vmem_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_start,
  input  logic  rd_end,
  input  logic  wr_start,
  input  logic  wr_end,
  input  off_t  bus_addr,
  input  byte_t bus_wdata,
  input  ptr_t  ptr,
  input  sel_t  sel,
  input  byte_t pre_data,
  output byte_t bus_rdata,
  output off_t  rcap_off,
  output off_t  wcap_off,
  output byte_t wcap_data,
  output logic  port_rd_done,
  output logic  port_wr_done,
  output logic  reg_we
);
  // read offset captured at recognition, not at release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcap_off  <= OFF_LO;
      bus_rdata <= '0;
    end else if (rd_start) begin
      rcap_off  <= bus_addr;
      bus_rdata <= read_mux(bus_addr, ptr, sel, pre_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcap_off  <= OFF_LO;
      wcap_data <= '0;
    end else if (wr_start) begin
      wcap_off  <= bus_addr;
      wcap_data <= bus_wdata;
    end
  end

  assign port_rd_done = rd_end && (rcap_off == OFF_PORT);
  assign port_wr_done = wr_end && (wcap_off == OFF_PORT);
  assign reg_we       = wr_end && (wcap_off != OFF_PORT);
endmodule

// File: rtl/vmem_pointer.sv
module vmem_pointer
  import vmem_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  reg_we,
  input  off_t  reg_off,
  input  byte_t reg_data,
  input  logic  advance,
  output ptr_t  ptr,
  output sel_t  sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      sel <= '0;
    end else if (reg_we) begin
      ptr <= ptr_load(ptr, reg_off, reg_data);
      if (reg_off == OFF_HI) sel <= reg_data[7:4];
    end else if (advance) begin
      ptr <= ptr_next(ptr, sel);
    end
  end
endmodule

// File: rtl/vmem_prefetch.sv
module vmem_prefetch
  import vmem_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ptr_touch,
  input  logic  mem_wr_en,
  input  byte_t mem_rdata,
  output logic  mem_rd_en,
  output logic  fetch_req,
  output byte_t pre_data
);
  logic pend;

  assign mem_rd_en = fetch_req & ~mem_wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_req <= 1'b1;
      pend      <= 1'b0;
      pre_data  <= '0;
    end else begin
      fetch_req <= ptr_touch | (fetch_req & mem_wr_en);
      pend      <= mem_rd_en;
      if (pend) pre_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/vmem_host_port.sv
module vmem_host_port
  import vmem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs_n,
  input  logic        bus_rd_n,
  input  logic        bus_wr_n,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [16:0] mem_addr,
  output logic        mem_rd_en,
  output logic        mem_wr_en,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  logic  rd_start, rd_end, wr_start, wr_end;
  logic  port_rd_done, port_wr_done, reg_we, advance, fetch_req;
  off_t  rcap_off, wcap_off;
  byte_t wcap_data, pre_data;
  ptr_t  ptr;
  sel_t  sel;

  vmem_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n(bus_cs_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .rd_start(rd_start), .rd_end(rd_end),
    .wr_start(wr_start), .wr_end(wr_end)
  );

  vmem_access_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .rd_start(rd_start), .rd_end(rd_end),
    .wr_start(wr_start), .wr_end(wr_end),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ptr(ptr), .sel(sel), .pre_data(pre_data),
    .bus_rdata(bus_rdata),
    .rcap_off(rcap_off), .wcap_off(wcap_off), .wcap_data(wcap_data),
    .port_rd_done(port_rd_done), .port_wr_done(port_wr_done),
    .reg_we(reg_we)
  );

  assign advance = port_rd_done | port_wr_done;

  vmem_pointer u_ptr (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_off(wcap_off), .reg_data(wcap_data),
    .advance(advance), .ptr(ptr), .sel(sel)
  );

  assign mem_wr_en = port_wr_done;
  assign mem_wdata = wcap_data;
  assign mem_addr  = ptr;

  vmem_prefetch u_pre (
    .clk(clk), .rst_n(rst_n),
    .ptr_touch(reg_we | advance),
    .mem_wr_en(mem_wr_en), .mem_rdata(mem_rdata),
    .mem_rd_en(mem_rd_en), .fetch_req(fetch_req),
    .pre_data(pre_data)
  );
endmodule

// File: rtl/vmem_host_port_chk.sv
module vmem_host_port_chk
  import vmem_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  rd_start,
  input logic  rd_end,
  input logic  wr_end,
  input logic  port_rd_done,
  input logic  mem_wr_en,
  input logic  mem_rd_en,
  input logic  fetch_req,
  input ptr_t  ptr,
  input sel_t  sel,
  input byte_t bus_rdata
);
  ptr_t exp_next;
  always_comb exp_next = ptr + (sel == '0 ? ptr_t'(0) : (ptr_t'(1) << (sel - sel_t'(1))));

  assert_single_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);

  assert_read_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd_done && !wr_end) |=> ptr == $past(exp_next));

  assert_write_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !rd_end) |=> ptr == $past(exp_next));

  assert_ptr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_end && !wr_end) |=> ($stable(ptr) && $stable(sel)));

  assert_refetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> (fetch_req && (mem_rd_en || mem_wr_en)));

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(bus_rdata));
endmodule

bind vmem_host_port vmem_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_start(rd_start), .rd_end(rd_end), .wr_end(wr_end),
  .port_rd_done(port_rd_done), .mem_wr_en(mem_wr_en),
  .mem_rd_en(mem_rd_en), .fetch_req(fetch_req),
  .ptr(ptr), .sel(sel), .bus_rdata(bus_rdata)
);

// File: tb/test_vmem_host_port.sv
module test_vmem_host_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [16:0] mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vmem_host_port i_vmem_host_port (
    .clk(clk), .rst_n(rst_n),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // small synchronous RAM, aliased on the low 12 address bits
  logic [7:0] ram [4096];
  logic [7:0] mdl [4096];

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37) + ((i >> 8) * 11) + 5);
  endfunction

  always @(posedge clk) begin
    if (mem_wr_en) ram[mem_addr[11:0]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= ram[mem_addr[11:0]];
  end

  // bench model of the register window
  logic [16:0] m_ptr = '0;
  logic [3:0]  m_sel = '0;

  function automatic logic [16:0] m_step(logic [3:0] s);
    logic [16:0] v;
    v = 17'd1;
    if (s == 4'd0) return 17'd0;
    for (int k = 1; k < int'(s); k++) v = v * 2;
    return v;
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] off);
    case (off)
      2'd0: return m_ptr[7:0];
      2'd1: return m_ptr[15:8];
      2'd2: return {m_sel, 3'b000, m_ptr[16]};
      default: return mdl[m_ptr[11:0]];
    endcase
  endfunction

  // scoreboard
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] mon_data;
  event       mon_ev;

  always begin
    @(mon_ev);
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL monitor: result with no expected item, got %02h", mon_data);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (mon_data !== e) begin
        errors++;
        $display("FAIL %s: bus_rdata=%02h expected %02h", t, mon_data, e);
      end
    end
  end

  task automatic direct_check(string t, logic [7:0] act, logic [7:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", t, act, e);
    end
  endtask

  task automatic bus_write(logic [1:0] off, logic [7:0] d, bit cs = 1'b1);
    @(posedge clk); #2;
    bus_addr = off; bus_wdata = d;
    #2; bus_cs_n = ~cs; bus_wr_n = 1'b0;
    repeat (6) @(posedge clk);
    #2; bus_wr_n = 1'b1; bus_cs_n = 1'b1;
    repeat (7) @(posedge clk);
    if (cs) begin
      case (off)
        2'd0: m_ptr[7:0] = d;
        2'd1: m_ptr[15:8] = d;
        2'd2: begin m_ptr[16] = d[0]; m_sel = d[7:4]; end
        default: begin
          mdl[m_ptr[11:0]] = d;
          m_ptr = m_ptr + m_step(m_sel);
        end
      endcase
    end
  endtask

  // alt >= 0: address moved to alt before release; hold = strobe cycles
  task automatic bus_read(logic [1:0] off, string t, int alt = -1, int hold = 6);
    exp_q.push_back(m_read(off));
    tag_q.push_back(t);
    @(posedge clk); #2;
    bus_addr = off;
    #2; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    repeat (hold) @(posedge clk);
    #2; mon_data = bus_rdata; -> mon_ev;
    if (alt >= 0) bus_addr = alt[1:0];
    #1; bus_rd_n = 1'b1; bus_cs_n = 1'b1;
    repeat (7) @(posedge clk);
    if (off == 2'd3) m_ptr = m_ptr + m_step(m_sel);
  endtask

  task automatic stray_read(logic [1:0] off);
    @(posedge clk); #2;
    bus_addr = off;
    #2; bus_rd_n = 1'b0;
    repeat (8) @(posedge clk);
    #2; bus_rd_n = 1'b1;
    repeat (7) @(posedge clk);
  endtask

  task automatic set_ptr(logic [16:0] p, logic [3:0] s);
    bus_write(2'd0, p[7:0]);
    bus_write(2'd1, p[15:8]);
    bus_write(2'd2, {s, 3'b000, p[16]});
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      ram[i] = pat(i);
      mdl[i] = pat(i);
    end
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (8) @(posedge clk);
    #2;
    direct_check("R1 bus_rdata after reset", bus_rdata, 8'h00);
    bus_read(2'd0, "R1 pointer low after reset");
    bus_read(2'd2, "R1 selector after reset");

    // R2: field loads and readback, bits 3:1 of offset 2 dropped
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hC3);
    bus_write(2'd2, 8'h7F);
    m_ptr[16] = 1'b1; m_sel = 4'h7;
    bus_read(2'd0, "R2 offset0 readback");
    bus_read(2'd1, "R2 offset1 readback");
    bus_read(2'd2, "R2 offset2 readback (bits 3:1 zero)");

    // R4/R9: example sequence 0x1B900 step 1
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'hB9);
    bus_write(2'd2, 8'h11);
    bus_read(2'd3, "R3 R9 first data read at 1B900");
    bus_read(2'd3, "R4 second data read at 1B901");
    bus_read(2'd0, "R4 pointer low after two reads");

    // R4: selector 5 (step 16) and selector 0 (step 0)
    set_ptr(17'h00010, 4'd5);
    bus_read(2'd3, "R4 sel5 read at 0x10");
    bus_read(2'd3, "R4 sel5 read at 0x20");
    set_ptr(17'h00123, 4'd0);
    bus_read(2'd3, "R4 sel0 read");
    bus_read(2'd3, "R4 sel0 repeat same byte");
    bus_read(2'd0, "R4 sel0 pointer unchanged");
    set_ptr(17'h00004, 4'd15);
    bus_read(2'd3, "R4 sel15 read");
    bus_read(2'd1, "R4 sel15 pointer mid byte");

    // R5: address moved away before release on a data read
    set_ptr(17'h00200, 4'd1);
    bus_read(2'd3, "R5 data read with address moved to 0", 0);
    bus_read(2'd3, "R5 next read sees advanced pointer");
    bus_read(2'd1, "R5 offset1 read moved to 3", 3);
    bus_read(2'd0, "R5 no advance after non-data read");

    // R6: strobes with chip-select high
    stray_read(2'd3);
    bus_write(2'd0, 8'hEE, 1'b0);
    bus_write(2'd3, 8'h99, 1'b0);
    bus_read(2'd0, "R6 pointer unchanged by stray strobes");
    bus_read(2'd3, "R6 memory unchanged by stray write");

    // R7: data-port write then readback
    set_ptr(17'h00300, 4'd1);
    bus_write(2'd3, 8'hA5);
    bus_write(2'd3, 8'h3C);
    bus_read(2'd0, "R7 pointer advanced by writes");
    set_ptr(17'h00300, 4'd1);
    bus_read(2'd3, "R7 first written byte");
    bus_read(2'd3, "R7 second written byte");

    // R8: wrap at 2^17
    set_ptr(17'h1FFFF, 4'd1);
    bus_read(2'd3, "R8 read at top address");
    bus_read(2'd0, "R8 wrapped offset0");
    bus_read(2'd2, "R8 wrapped offset2");

    // R10: long strobe gives one advance
    set_ptr(17'h00400, 4'd1);
    bus_read(2'd3, "R10 long strobe read", -1, 40);
    bus_read(2'd0, "R10 single advance");

    repeat (10) @(posedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule